// File: doc/BRIEF.md
# Conversion-Gated Serial ADC Reader

This block is the host side of a three-wire link to a serial analog-to-digital converter. The converter has no chip select. One trigger line, driven by the host, sequences everything: raising it starts a conversion, holding it high covers the conversion time, and lowering it enables the converter's data output and starts the readout. The host then sends a serial clock that idles low. The converter changes its data bit after each falling clock edge, and the host samples the bit on the rising edge. A result is exactly `DATA_W` bits long and arrives most significant bit first. If the host sends more clocks after the last bit, the converter returns only zeros.

A one-cycle `start_i` request begins a read. The trigger is held high for `CONV_TIME` system clocks. The serial clock then runs with a half-period of `SCK_HALF` system clocks. When the last bit has been taken, the assembled word appears on `data_o` together with a one-cycle `valid_o` strobe. The parameter `SLEEP_ON_DONE` selects what the trigger does between reads. It can return high in the cycle the result appears, which puts the converter into its low-power sleep state. Otherwise it stays low until the next request raises it.

Top module: `adc_conv_host`

## Requirements
- R1: While `rst_n` is low, `trig_o`, `ser_clk_o`, `busy_o` and `valid_o` are 0 and `data_o` is all zeros.
- R2: When `start_i` is seen high while idle, `busy_o` and `trig_o` are high in the next cycle. The trigger stays high, with `busy_o` set, for exactly `CONV_TIME` cycles and then falls.
- R3: The serial clock is low while idle and while the trigger is high. Its first rising edge comes `SCK_HALF` cycles after the trigger falls. Each high phase lasts `SCK_HALF` cycles, and successive rising edges are `2*SCK_HALF` cycles apart.
- R4: Each read produces exactly `DATA_W` rising serial-clock edges.
- R5: `ser_din_i` is sampled at each rising serial-clock edge. The first sample becomes bit `DATA_W-1` of `data_o` and the last becomes bit 0.
- R6: `valid_o` is high for exactly one cycle per read. In that cycle `busy_o` is already low. `data_o` keeps the result after the strobe until the next result.
- R7: A `start_i` request made while `busy_o` is high is ignored: it neither extends nor restarts the trigger phase and adds no extra result.
- R8: A request present in the cycle `valid_o` is high is accepted. Held high continuously, `start_i` gives one result every `CONV_TIME + 2*SCK_HALF*DATA_W + 2` cycles.
- R9: With `SLEEP_ON_DONE` = 0 the trigger is low when `valid_o` is high and stays low while idle. With `SLEEP_ON_DONE` = 1 it is high from the `valid_o` cycle on, throughout idle, and through the next trigger phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Request to start one conversion and readout |
| ser_din_i | input | 1 | Serial data from the converter |
| trig_o | output | 1 | Conversion trigger line to the converter |
| ser_clk_o | output | 1 | Serial clock to the converter, idles low |
| busy_o | output | 1 | A read is in progress |
| data_o | output | DATA_W | Last assembled result |
| valid_o | output | 1 | One-cycle strobe marking a new result |

## Verification
The result strobe and the acceptance of the next request can fall in the same cycle. The bench provokes this by holding `start_i` high through a burst of reads. It checks that each strobe is followed by a new trigger phase at the fixed spacing, and that each burst result matches the word the converter model was loaded with for that read. A second pair of functions is checked under the same stimulus. Extra requests are pulsed during the trigger phase and the shift phase, and the bench judges that neither the trigger length nor the number of results moves.

// File: rtl/adc_host_pkg.sv
// Package: shared types for the conversion-gated ADC reader.
// Assumes nothing beyond a single clock domain.
package adc_host_pkg;

    // Sequencer states of the host reader
    typedef enum logic [2:0] {
        ST_IDLE       = 3'd0,
        ST_CONVERT    = 3'd1,
        ST_WAIT_FIRST = 3'd2,
        ST_SHIFT      = 3'd3,
        ST_DONE       = 3'd4
    } host_state_t;

endpackage

// File: rtl/adc_dn_timer.sv
// Module: loadable down counter that reports when it has reached zero.
// Assumes load has priority over decrement; it holds at zero.
module adc_dn_timer #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [WIDTH-1:0] load_val,
    input  logic             dec,
    output logic             zero_o
);

    logic [WIDTH-1:0] cnt;

    // Counter register: load, count down, or hold
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (dec && (cnt != '0)) begin
            cnt <= cnt - 1'b1;
        end
    end

    // Expiry flag
    assign zero_o = (cnt == '0);

endmodule

// File: rtl/adc_rx_shift.sv
// Module: serial-to-parallel register, MSB first, with a count of bits taken.
// Assumes the sequencer never requests more than DATA_W captures per word.
module adc_rx_shift #(
    parameter int DATA_W = 16,
    localparam int CNT_W = $clog2(DATA_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              cap,
    input  logic              din,
    output logic [DATA_W-1:0] word_o,
    output logic [CNT_W-1:0]  count_o
);

    // Shift register and bit counter
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            word_o  <= '0;
            count_o <= '0;
        end else if (cap) begin
            word_o  <= {word_o[DATA_W-2:0], din};
            count_o <= count_o + 1'b1;
        end
    end

    // R4: never more captures than the word holds
    assert_bit_count_max_R4: assert property (@(posedge clk) disable iff (!rst_n)
        count_o <= CNT_W'(DATA_W));

    // R4: no capture once the word is full unless it is cleared first
    assert_no_extra_capture_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (count_o == CNT_W'(DATA_W)) && !clr |-> !cap);

endmodule

// File: rtl/adc_conv_host.sv
// Module: host reader for a converter driven by a single conversion trigger
// line. It holds the trigger high for the conversion time, lowers it, clocks
// out DATA_W bits with a divided serial clock, samples each bit on the rising
// edge and presents the word with a one-cycle strobe.
// Assumes the converter updates its data bit after each falling clock edge.
module adc_conv_host
    import adc_host_pkg::*;
#(
    parameter int DATA_W        = 16,
    parameter int SCK_HALF      = 2,
    parameter int CONV_TIME     = 6,
    parameter bit SLEEP_ON_DONE = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              ser_din_i,
    output logic              trig_o,
    output logic              ser_clk_o,
    output logic              busy_o,
    output logic [DATA_W-1:0] data_o,
    output logic              valid_o
);

    localparam int CT_W  = $clog2(CONV_TIME + 1);
    localparam int PT_W  = $clog2(SCK_HALF + 1);
    localparam int CNT_W = $clog2(DATA_W + 1);
    localparam logic [CT_W-1:0]  CT_LOAD  = CT_W'(CONV_TIME - 1);
    localparam logic [PT_W-1:0]  PT_LOAD  = PT_W'(SCK_HALF - 1);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W);

    host_state_t       state;
    logic              ct_load, ct_dec, ct_zero;
    logic              pt_load, pt_dec, pt_zero;
    logic              sh_clr, sh_cap;
    logic [DATA_W-1:0] sh_word;
    logic [CNT_W-1:0]  sh_count;

    // Conversion-time timer
    adc_dn_timer #(.WIDTH(CT_W)) u_conv_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ct_load),
        .load_val (CT_LOAD),
        .dec      (ct_dec),
        .zero_o   (ct_zero)
    );

    // Serial-clock half-period timer
    adc_dn_timer #(.WIDTH(PT_W)) u_phase_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (pt_load),
        .load_val (PT_LOAD),
        .dec      (pt_dec),
        .zero_o   (pt_zero)
    );

    // Incoming bit assembly
    adc_rx_shift #(.DATA_W(DATA_W)) u_rx_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (sh_clr),
        .cap     (sh_cap),
        .din     (ser_din_i),
        .word_o  (sh_word),
        .count_o (sh_count)
    );

    // Timer and capture controls derived from the current state
    always_comb begin
        ct_load = 1'b0;
        ct_dec  = 1'b0;
        pt_load = 1'b0;
        pt_dec  = 1'b0;
        sh_clr  = 1'b0;
        sh_cap  = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (start_i) begin
                    ct_load = 1'b1;
                    sh_clr  = 1'b1;
                end
            end
            ST_CONVERT: begin
                if (ct_zero) pt_load = 1'b1;
                else         ct_dec  = 1'b1;
            end
            ST_WAIT_FIRST: begin
                if (pt_zero) begin
                    sh_cap  = 1'b1;
                    pt_load = 1'b1;
                end else begin
                    pt_dec = 1'b1;
                end
            end
            ST_SHIFT: begin
                if (pt_zero) begin
                    pt_load = 1'b1;
                    sh_cap  = !ser_clk_o;
                end else begin
                    pt_dec = 1'b1;
                end
            end
            default: ;
        endcase
    end

    // Sequencer and output registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            trig_o    <= 1'b0;
            ser_clk_o <= 1'b0;
            data_o    <= '0;
            valid_o   <= 1'b0;
        end else begin
            valid_o <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (start_i) begin
                        trig_o <= 1'b1;
                        state  <= ST_CONVERT;
                    end
                end
                ST_CONVERT: begin
                    if (ct_zero) begin
                        trig_o <= 1'b0;
                        state  <= ST_WAIT_FIRST;
                    end
                end
                ST_WAIT_FIRST: begin
                    if (pt_zero) begin
                        ser_clk_o <= 1'b1;
                        state     <= ST_SHIFT;
                    end
                end
                ST_SHIFT: begin
                    if (pt_zero) begin
                        ser_clk_o <= !ser_clk_o;
                        if (ser_clk_o && (sh_count == LAST_BIT)) state <= ST_DONE;
                    end
                end
                ST_DONE: begin
                    data_o  <= sh_word;
                    valid_o <= 1'b1;
                    trig_o  <= SLEEP_ON_DONE;
                    state   <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Busy whenever a read is in progress
    assign busy_o = (state != ST_IDLE);

    // R2: a read begins with the trigger high
    assert_trig_on_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> trig_o);

    // R3: serial clock stays low while idle or while the trigger is high
    assert_sck_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o || trig_o) |-> !ser_clk_o);

    // R6: strobe lasts a single cycle and comes with busy low
    assert_valid_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);
    assert_valid_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> !busy_o);

    // R7: a request during the shift phase does not restart the trigger
    assert_no_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SHIFT) && start_i |=> !trig_o);

    // R9: trigger level in the strobe cycle follows the sleep option
    assert_trig_after_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (trig_o == SLEEP_ON_DONE));

endmodule

// File: tb/adc_conv_host_tb.sv
// Bench: two readers (trigger left low / trigger returned high) share one
// start request. Each is read by its own converter model. Words are swept
// through walking ones, walking zeros, extremes and mixed patterns.
module adc_conv_model #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              trig,
    input  logic              sck,
    input  logic [DATA_W-1:0] word_in,
    output logic              sdo
);
    int                idx = 0;
    logic              sck_prev = 1'b0;
    logic [DATA_W-1:0] w = '0;

    // Latch word while triggered; advance a bit after each falling clock
    always @(negedge clk) begin
        if (trig) begin
            idx <= 0;
            w   <= word_in;
        end else if (sck_prev && !sck) begin
            idx <= idx + 1;
        end
        sck_prev <= sck;
    end

    assign sdo = trig ? 1'b0 : ((idx < DATA_W) ? w[DATA_W-1-idx] : 1'b0);
endmodule

module adc_conv_host_tb;
    localparam int W = 16;
    localparam int H = 2;
    localparam int C = 6;
    localparam int PERIOD = C + 2 * H * W + 2;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [W-1:0] cur_word = '0;
    logic         sdo_a, trig_a, sck_a, busy_a, valid_a;
    logic         sdo_b, trig_b, sck_b, busy_b, valid_b;
    logic [W-1:0] data_a, data_b;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    int n_valid = 0;
    int n_expect = 0;
    bit burst = 1'b0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    adc_conv_host #(.DATA_W(W), .SCK_HALF(H), .CONV_TIME(C), .SLEEP_ON_DONE(1'b0)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .ser_din_i(sdo_a),
        .trig_o(trig_a), .ser_clk_o(sck_a), .busy_o(busy_a), .data_o(data_a), .valid_o(valid_a));

    adc_conv_host #(.DATA_W(W), .SCK_HALF(H), .CONV_TIME(C), .SLEEP_ON_DONE(1'b1)) u_dut_slp (
        .clk(clk), .rst_n(rst_n), .start_i(start), .ser_din_i(sdo_b),
        .trig_o(trig_b), .ser_clk_o(sck_b), .busy_o(busy_b), .data_o(data_b), .valid_o(valid_b));

    adc_conv_model #(.DATA_W(W)) u_mdl_a (.clk(clk), .trig(trig_a), .sck(sck_a), .word_in(cur_word), .sdo(sdo_a));
    adc_conv_model #(.DATA_W(W)) u_mdl_b (.clk(clk), .trig(trig_b), .sck(sck_b), .word_in(cur_word), .sdo(sdo_b));

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Monitor state
    logic pa_trig = 0, pa_sck = 0, pa_busy = 0, pa_valid = 0;
    logic pb_busy = 0, pb_valid = 0;
    int run_a = 0, run_b = 0, rises_a = 0, t_fall = 0, t_rise = 0, t_valid = -1;
    logic [W-1:0] exp_a = '0, exp_b = '0;

    // Monitor for the reader that leaves the trigger low
    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (busy_a && trig_a) run_a++;
            if (busy_a && !pa_busy) exp_a = cur_word;
            if (pa_trig && !trig_a) t_fall = cyc;
            if (!pa_sck && sck_a) begin
                rises_a++;
                if (rises_a == 1) chk(cyc - t_fall == H, "R3", "first rise delay", cyc - t_fall, H);
                else chk(cyc - t_rise == 2 * H, "R3", "rise spacing", cyc - t_rise, 2 * H);
                t_rise = cyc;
            end
            if (pa_sck && !sck_a) chk(cyc - t_rise == H, "R3", "high phase", cyc - t_rise, H);
            if (pa_valid && !valid_a && !busy_a)
                chk(data_a == exp_a, "R6", "data held after strobe", int'(data_a), int'(exp_a));
            if (valid_a) begin
                n_valid++;
                chk(!pa_valid, "R6", "strobe length", int'(pa_valid), 0);
                chk(!busy_a, "R6", "busy at strobe", int'(busy_a), 0);
                chk(data_a == exp_a, "R5", "result word", int'(data_a), int'(exp_a));
                chk(rises_a == W, "R4", "rising edges", rises_a, W);
                chk(run_a == C, "R2", "trigger length", run_a, C);
                chk(!trig_a, "R9", "trigger at strobe (no sleep)", int'(trig_a), 0);
                if (burst && t_valid >= 0)
                    chk(cyc - t_valid == PERIOD, "R8", "burst spacing", cyc - t_valid, PERIOD);
                t_valid = cyc;
                run_a = 0;
                rises_a = 0;
            end
            if (busy_b && trig_b) run_b++;
            if (busy_b && !pb_busy) exp_b = cur_word;
            if (valid_b) begin
                chk(data_b == exp_b, "R5", "result word (sleep)", int'(data_b), int'(exp_b));
                chk(trig_b, "R9", "trigger at strobe (sleep)", int'(trig_b), 1);
                chk(run_b == C, "R9", "trigger phase (sleep)", run_b, C);
                run_b = 0;
            end
        end
        pa_trig = trig_a; pa_sck = sck_a; pa_busy = busy_a; pa_valid = valid_a;
        pb_busy = busy_b; pb_valid = valid_b;
    end

    task automatic wait_valid();
        do @(negedge clk); while (!valid_a);
    endtask

    task automatic txn(input logic [W-1:0] w, input bit noisy);
        cur_word = w;
        n_expect++;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (noisy) begin
            // R7: extra requests during trigger phase and during shifting
            repeat (2) @(negedge clk);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            repeat (C + H + 4) @(negedge clk);
            start = 1'b1;
            repeat (3) @(negedge clk);
            start = 1'b0;
        end
        wait_valid();
        repeat (3) @(negedge clk);
        chk(!sck_a && !sck_b, "R3", "clock low when idle", int'(sck_a | sck_b), 0);
        chk(!trig_a, "R9", "trigger idle low", int'(trig_a), 0);
        chk(trig_b, "R9", "trigger idle high (sleep)", int'(trig_b), 1);
    endtask

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            chk(1'b0, "WDOG", "watchdog expired", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    // Stimulus
    initial begin
        repeat (3) @(negedge clk);
        chk(!trig_a && !sck_a && !busy_a && !valid_a, "R1", "control outputs in reset", 
            int'({trig_a, sck_a, busy_a, valid_a}), 0);
        chk(data_a == '0 && data_b == '0, "R1", "data in reset", int'(data_a | data_b), 0);
        chk(!trig_b && !busy_b && !valid_b, "R1", "sleep variant in reset", int'({trig_b, busy_b, valid_b}), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        for (int i = 0; i < W; i++) txn(W'(1) << i, i[0]);
        for (int i = 0; i < W; i++) txn(~(W'(1) << i), !i[0]);
        txn('0, 1'b0);
        txn('1, 1'b1);
        for (int i = 0; i < 8; i++) txn(W'(i * 40503) ^ W'(23130), i[1]);
        // R8: start held high through a burst of reads
        burst = 1'b1;
        t_valid = -1;
        cur_word = W'(16'hC3A5);
        start = 1'b1;
        for (int k = 0; k < 8; k++) begin
            n_expect++;
            wait_valid();
            cur_word = W'(k * 4099 + 77);
            if (k == 7) start = 1'b0;
        end
        burst = 1'b0;
        repeat (PERIOD + 10) @(negedge clk);
        chk(n_valid == n_expect, "R7", "result count", n_valid, n_expect);
        chk(!busy_a, "R7", "idle after burst", int'(busy_a), 0);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule